// File: doc/BRIEF.md
# Cascaded 32-Input Highest-Bit Priority Encoder

This block turns a 32-bit request vector into the 5-bit position of the highest-numbered active request. It is purely combinational. It is built from four identical 8-input encoder slices. Each slice takes an enable input and drives two flags. The first flag reports that the slice was enabled and found a request. The second flag passes the enable down when the slice was enabled and found nothing.

The slices form a chain ordered by priority. The slice covering bits 31 to 24 receives the global enable. Each lower slice is enabled only by the pass-down flag of the slice directly above it. As a result, at most one slice can be enabled and active at a time. The top level builds its outputs from the slice flags as follows:

- The upper two bits of the index are the number of the active slice.
- The lower three bits of the index are the OR of the slice outputs.
- The "found" flag is the OR of the slice hit flags.
- The "nothing found" flag is the pass-down flag of the bottom slice.

Top module: `prienc_cascade`

## Requirements
- R1: With `en_i`=1 and at least one request bit set, `idx_o` equals the position of the highest set bit of `req_i`.
- R2: `any_o` is 1 exactly when `en_i`=1 and `req_i` is non-zero.
- R3: `none_o` is 1 exactly when `en_i`=1 and `req_i` is all zero.
- R4: With `en_i`=0, `idx_o`, `any_o` and `none_o` are all 0 for every value of `req_i`.
- R5: With `en_i`=1 and `req_i` all zero, `idx_o` is 0.
- R6: `idx_o[4:3]` names the group holding the winning bit: 3 for bits 31..24, 2 for 23..16, 1 for 15..8, 0 for 7..0. `idx_o[2:0]` is the bit offset inside that group.
- R7: Request bits below the winning bit have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Global enable, fed to the top group first |
| req_i | input | 32 | Request vector; the highest set bit wins |
| idx_o | output | 5 | Encoded position of the winning request |
| any_o | output | 1 | Enabled and at least one request is set |
| none_o | output | 1 | Enabled and no request is set |

## Verification
The block holds no state, so any fault shows up at the ports at once, in the same evaluation as the stimulus.

A break in the enable chain shows up as a missing index or a wrong flag, but only when every request sits in the groups below the break. For this reason the bench walks a single set bit through every position. It also applies every pair of set bits, so each lower group is reached through the pass-down path. The pairs also show whether lower requests leak into the result when a higher group wins. Further mixed random vectors, with the enable both high and low, expose faults that only appear with many bits set.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
  parameter int unsigned SLICE_W    = 8;
  parameter int unsigned NUM_SLICES = 4;
  localparam int unsigned TOTAL_W   = SLICE_W * NUM_SLICES;
  localparam int unsigned OFF_W     = $clog2(SLICE_W);
  localparam int unsigned GRP_W     = $clog2(NUM_SLICES);
  localparam int unsigned IDX_W     = OFF_W + GRP_W;
endpackage

// File: rtl/prienc_slice.sv
module prienc_slice #(
  parameter int unsigned W     = 8,
  parameter int unsigned OFF_W = $clog2(W)
) (
  input  logic             en_i,
  input  logic [W-1:0]     req_i,
  output logic [OFF_W-1:0] off_o,
  output logic             hit_o,
  output logic             pass_o
);
  logic [OFF_W-1:0] top_pos;

  // scan upward, so the last set bit found is the highest
  always_comb begin
    top_pos = '0;
    for (int unsigned b = 0; b < W; b++) begin
      if (req_i[b]) top_pos = OFF_W'(b);
    end
  end

  assign hit_o  = en_i & (|req_i);
  assign pass_o = en_i & ~(|req_i);
  assign off_o  = hit_o ? top_pos : '0;

  always_comb begin
    // R4: a disabled slice is silent
    p_slice_quiet_r4: assert (en_i || (off_o == '0 && !hit_o && !pass_o));
    // R1: the reported bit is set
    p_slice_bit_set_r1: assert (!hit_o || req_i[off_o]);
    // R1: no bit above the reported one is set
    p_slice_nothing_above_r1: assert (!hit_o || ((req_i >> off_o) >> 1) == '0);
  end
endmodule

// File: rtl/prienc_merge.sv
module prienc_merge #(
  parameter int unsigned N     = 4,
  parameter int unsigned OFF_W = 3,
  parameter int unsigned GRP_W = $clog2(N)
) (
  input  logic [N-1:0][OFF_W-1:0] off_i,
  input  logic [N-1:0]            hit_i,
  output logic [GRP_W+OFF_W-1:0]  idx_o,
  output logic                    any_o
);
  logic [GRP_W-1:0] grp;
  logic [OFF_W-1:0] off;

  always_comb begin
    grp = '0;
    off = '0;
    for (int unsigned s = 0; s < N; s++) begin
      if (hit_i[s]) grp = grp | GRP_W'(s);
      off = off | off_i[s];
    end
  end

  assign idx_o = {grp, off};
  assign any_o = |hit_i;

  always_comb begin
    // R6: the enable chain lets at most one group hit
    p_single_group_r6: assert ($onehot0(hit_i));
  end
endmodule

// File: rtl/prienc_cascade.sv
module prienc_cascade
  import prienc_pkg::*;
(
  input  logic               en_i,
  input  logic [TOTAL_W-1:0] req_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o,
  output logic               none_o
);
  logic [NUM_SLICES:0]                en_chain;
  logic [NUM_SLICES-1:0][OFF_W-1:0]   off;
  logic [NUM_SLICES-1:0]              hit;

  assign en_chain[NUM_SLICES] = en_i;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    prienc_slice #(.W(SLICE_W), .OFF_W(OFF_W)) u_slice (
      .en_i  (en_chain[s+1]),
      .req_i (req_i[s*SLICE_W +: SLICE_W]),
      .off_o (off[s]),
      .hit_o (hit[s]),
      .pass_o(en_chain[s])
    );
  end

  prienc_merge #(.N(NUM_SLICES), .OFF_W(OFF_W), .GRP_W(GRP_W)) u_merge (
    .off_i(off),
    .hit_i(hit),
    .idx_o(idx_o),
    .any_o(any_o)
  );

  assign none_o = en_chain[0];

  always_comb begin
    // R2/R3: the two flags never coincide, and exactly one is set when enabled
    p_flags_exclusive_r2: assert (!(any_o && none_o));
    p_flags_cover_r3: assert (!en_i || (any_o ^ none_o));
    // R1: the winning bit is set and nothing above it is
    p_winner_set_r1: assert (!any_o || req_i[idx_o]);
    p_winner_top_r1: assert (!any_o || ((req_i >> idx_o) >> 1) == '0);
    // R5: with no hit, the index is zero
    p_idx_zero_r5: assert (any_o || idx_o == '0);
    // R4: a disabled block is silent
    p_off_quiet_r4: assert (en_i || (!any_o && !none_o && idx_o == '0));
  end
endmodule

// File: tb/prienc_cascade_tb.sv
`timescale 1ns/1ps
module prienc_cascade_tb;
  localparam int NV = 10;

  // {en, req[31:0], idx[4:0], any, none}
  localparam logic [39:0] VECS [NV] = '{
    {1'b1, 32'h0000_0001, 5'd0,  1'b1, 1'b0},
    {1'b1, 32'h8000_0000, 5'd31, 1'b1, 1'b0},
    {1'b1, 32'h8000_0001, 5'd31, 1'b1, 1'b0},
    {1'b1, 32'h0000_0100, 5'd8,  1'b1, 1'b0},
    {1'b1, 32'h00FF_0000, 5'd23, 1'b1, 1'b0},
    {1'b1, 32'h0000_0000, 5'd0,  1'b0, 1'b1},
    {1'b0, 32'hFFFF_FFFF, 5'd0,  1'b0, 1'b0},
    {1'b1, 32'h0100_0080, 5'd24, 1'b1, 1'b0},
    {1'b1, 32'h0000_00FF, 5'd7,  1'b1, 1'b0},
    {1'b1, 32'h0001_8000, 5'd16, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        en;
  logic [31:0] req;
  logic [4:0]  idx;
  logic        any_f, none_f;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  prienc_cascade u_dut (
    .en_i  (en),
    .req_i (req),
    .idx_o (idx),
    .any_o (any_f),
    .none_o(none_f)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s en=%b req=%h actual=%0d expected=%0d", tag, en, req, act, exp);
    end
  endtask

  // reference: scan down from bit 31
  task automatic apply_ref(input logic e, input logic [31:0] r, input string tag);
    logic [4:0] ei = '0;
    logic       found = 1'b0;
    @(posedge clk);
    en  = e;
    req = r;
    for (int b = 31; b >= 0; b--) begin
      if (!found && r[b]) begin
        ei = 5'(b);
        found = 1'b1;
      end
    end
    if (!e) begin
      ei = '0;
    end
    @(negedge clk);
    cmp({tag, " R1/R5 idx"}, 32'(idx), 32'(ei));
    cmp({tag, " R2 any"}, 32'(any_f), 32'(e & found));
    cmp({tag, " R3 none"}, 32'(none_f), 32'(e & ~found));
  endtask

  initial begin
    en  = 1'b0;
    req = '0;
    // R4: idle state with the enable low
    @(negedge clk);
    cmp("R4 idle idx", 32'(idx), 0);
    cmp("R4 idle any", 32'(any_f), 0);
    cmp("R4 idle none", 32'(none_f), 0);

    // table of directed vectors
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      en  = VECS[i][39];
      req = VECS[i][38:7];
      @(negedge clk);
      cmp("R1/R6 table idx", 32'(idx), 32'(VECS[i][6:2]));
      cmp("R2 table any", 32'(any_f), 32'(VECS[i][1]));
      cmp("R3 table none", 32'(none_f), 32'(VECS[i][0]));
    end

    // R6: group number and offset of each single set bit
    for (int b = 0; b < 32; b++) begin
      apply_ref(1'b1, 32'h1 << b, "R6 onehot");
      cmp("R6 group", 32'(idx[4:3]), 32'(b / 8));
      cmp("R6 offset", 32'(idx[2:0]), 32'(b % 8));
      apply_ref(1'b0, 32'h1 << b, "R4 onehot off");
    end

    // R7: every pair of set bits; the lower bit must not matter
    for (int hi = 1; hi < 32; hi++) begin
      for (int lo = 0; lo < hi; lo++) begin
        apply_ref(1'b1, (32'h1 << hi) | (32'h1 << lo), "R7 twohot");
      end
    end

    // mixed random vectors, enable both ways
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r = $urandom;
      r = r >> ($urandom % 32);
      apply_ref(($urandom % 4) != 0, r, "R1 random");
    end

    // R4: all ones with the enable low
    apply_ref(1'b0, 32'hFFFF_FFFF, "R4 allones");
    // R5: all zero with the enable high
    apply_ref(1'b1, 32'h0, "R5 zero");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule